// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block sits between a set of peripheral interrupt request lines and the seven general-purpose priority inputs of a processor's core event logic. Every source carries a small programmable code that names which of the seven priority levels (7 through 13) it feeds. Each priority output is the plain OR of every request line whose code currently points at it, so several peripherals can share one level. One source can also be cut off from every level.

The codes live in a small bank of 32-bit words behind a simple write/read port. Reset loads a fixed grouping: errors and wakeup on the highest peripheral level; the clock and parallel DMA on the next; serial DMA, SPI/UART DMA, timers, GPIO, and memory DMA with the watchdog each on a lower level. Software can later move any source to any level by rewriting its code. The routing path from request to priority output is purely combinational. A rewritten code steers requests from the clock edge that captures the write.

Top module: `irq_level_router`

## Requirements
- R1: There are 24 sources, each with a 4-bit code. The code for source s sits in word s/8 at bits [4*(s%8)+3 : 4*(s%8)]. The words are at addresses 0, 1 and 2.
- R2: While `rst_n` is low, the codes are forced to the default grouping, which gives word 0 = 0x10000000, word 1 = 0x33322221 and word 2 = 0x66655444. Under this grouping, sources 0-6 use code 0, sources 7-8 use code 1, 9-12 use code 2, 13-15 use code 3, 16-18 use code 4, 19-20 use code 5 and 21-23 use code 6.
- R3: A code value v from 0 to 6 routes its source to `lvl_irq[v]`, which is priority level 7+v, and to no other output bit.
- R4: Each `lvl_irq` bit is the OR of all `src_irq` lines whose code selects it. The OR is combinational, so it follows `src_irq` in the same cycle. With no request active, all outputs are low.
- R5: A code value from 7 to 15 disconnects its source, so that source drives no output bit.
- R6: `reg_rdata` shows the stored word at `reg_addr` combinationally.
- R7: A write with `reg_we` high to address 0-2 replaces that whole word at the next rising clock edge. Routing and read-back use the old word up to that edge and the new word after it.
- R8: At address 3, a write changes no stored code and a read returns 0.
- R9: While `reg_we` is low, no stored code changes, whatever `reg_addr` and `reg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the code storage |
| rst_n | input | 1 | Asynchronous active-low reset; loads the default grouping |
| reg_we | input | 1 | Write strobe for the code words |
| reg_addr | input | 2 | Word address for both write and read |
| reg_wdata | input | 32 | Word to store |
| reg_rdata | output | 32 | Stored word at `reg_addr`, or 0 outside the bank |
| src_irq | input | 24 | Peripheral request lines, bit s is source s |
| lvl_irq | output | 7 | Priority outputs, bit v is level 7+v |

## Verification
Single-source sweeps under the reset grouping show whether each source lands on exactly the level its default code names. Multi-source patterns that share one level, or that spread across levels, separate an OR from a priority pick or a last-writer-wins merge. A write issued while a request is held shows whether the new code acts exactly one edge later and not earlier. Codes 7 and 15 show whether out-of-range values disconnect a source or wrap onto a real level. Writes to the unused address and writes with the strobe low, both carrying all-ones data, check that nothing stored is disturbed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Default level code for a source index; indices past the defined set stay disconnected.
  function automatic int unsigned default_code(input int unsigned src);
    if (src <= 6)       return 0;
    else if (src <= 8)  return 1;
    else if (src <= 12) return 2;
    else if (src <= 15) return 3;
    else if (src <= 18) return 4;
    else if (src <= 20) return 5;
    else if (src <= 23) return 6;
    else                return 15;
  endfunction

  // True when a code selects the given level index.
  function automatic bit code_hits_level(input int unsigned code, input int unsigned lvl);
    return code == lvl;
  endfunction

endpackage

// File: rtl/irq_assign_regs.sv
module irq_assign_regs #(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 32,
  parameter int FIELD_W  = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  output logic [NUM_REGS*REG_W-1:0] cfg_flat
);
  import irq_router_pkg::*;

  localparam int TOT_W   = NUM_REGS * REG_W;
  localparam int NUM_FLD = TOT_W / FIELD_W;

  function automatic logic [TOT_W-1:0] reset_image();
    logic [TOT_W-1:0] img;
    img = '0;
    for (int f = 0; f < NUM_FLD; f++) begin
      img[f*FIELD_W +: FIELD_W] = FIELD_W'(default_code(f));
    end
    return img;
  endfunction

  localparam logic [TOT_W-1:0] RESET_IMG = reset_image();

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    logic hit;
    assign hit = wr_en && (int'(wr_idx) == r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_flat[r*REG_W +: REG_W] <= RESET_IMG[r*REG_W +: REG_W];
      end else if (hit) begin
        cfg_flat[r*REG_W +: REG_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/irq_field_decode.sv
module irq_field_decode #(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 7,
  parameter int FIELD_W = 4
) (
  input  logic [NUM_SRC*FIELD_W-1:0] codes,
  output logic [NUM_SRC*NUM_LVL-1:0] sel_flat
);
  import irq_router_pkg::*;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [FIELD_W-1:0] code;
    assign code = codes[s*FIELD_W +: FIELD_W];
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign sel_flat[s*NUM_LVL + l] = code_hits_level(int'(code), l);
    end
  end

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 7
) (
  input  logic [NUM_SRC-1:0]         src_irq,
  input  logic [NUM_SRC*NUM_LVL-1:0] sel_flat,
  output logic [NUM_LVL-1:0]         lvl_irq
);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] column;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign column[s] = src_irq[s] & sel_flat[s*NUM_LVL + l];
    end
    assign lvl_irq[l] = |column;
  end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router #(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 7,
  parameter int FIELD_W = 4,
  parameter int REG_W   = 32,
  localparam int FLD_PER_REG = REG_W / FIELD_W,
  localparam int NUM_REGS    = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG,
  localparam int ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic [NUM_LVL-1:0] lvl_irq
);

  localparam int TOT_W = NUM_REGS * REG_W;

  logic [TOT_W-1:0]           cfg_flat;
  logic [NUM_SRC*NUM_LVL-1:0] sel_flat;
  logic                       addr_in_bank;

  assign addr_in_bank = int'(reg_addr) < NUM_REGS;

  irq_assign_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(reg_addr),
    .wr_data(reg_wdata), .cfg_flat(cfg_flat)
  );

  irq_field_decode #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W)
  ) u_dec (
    .codes(cfg_flat[NUM_SRC*FIELD_W-1:0]), .sel_flat(sel_flat)
  );

  irq_level_merge #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)
  ) u_merge (
    .src_irq(src_irq), .sel_flat(sel_flat), .lvl_irq(lvl_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (addr_in_bank) reg_rdata = cfg_flat[int'(reg_addr)*REG_W +: REG_W];
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC  = 24,
  parameter int NUM_LVL  = 7,
  parameter int FIELD_W  = 4,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 3,
  parameter int ADDR_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [REG_W-1:0]           reg_wdata,
  input logic [REG_W-1:0]           reg_rdata,
  input logic [NUM_SRC-1:0]         src_irq,
  input logic [NUM_LVL-1:0]         lvl_irq,
  input logic [NUM_REGS*REG_W-1:0]  cfg_flat,
  input logic [NUM_SRC*NUM_LVL-1:0] sel_flat
);
  import irq_router_pkg::*;

  localparam int TOT_W = NUM_REGS * REG_W;

  function automatic logic [TOT_W-1:0] expected_image();
    logic [TOT_W-1:0] img;
    img = '0;
    for (int f = 0; f < TOT_W / FIELD_W; f++) img[f*FIELD_W +: FIELD_W] = FIELD_W'(default_code(f));
    return img;
  endfunction

  localparam logic [TOT_W-1:0] IMG = expected_image();

  // Remember the last accepted write so the next cycle can be compared with it.
  logic              last_hit;
  logic [ADDR_W-1:0] last_addr;
  logic [REG_W-1:0]  last_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_hit  <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_hit  <= reg_we && (int'(reg_addr) < NUM_REGS);
      last_addr <= reg_addr;
      last_data <= reg_wdata;
    end
  end

  p_reset_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_flat == IMG);

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |-> cfg_flat[int'(last_addr)*REG_W +: REG_W] == last_data);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we || int'(reg_addr) >= NUM_REGS) |=> $stable(cfg_flat));

  p_oob_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= NUM_REGS) |-> reg_rdata == '0);

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |-> lvl_irq == '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    p_single_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_flat[s*NUM_LVL +: NUM_LVL]));
    p_disconnect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_flat[s*FIELD_W +: FIELD_W]) >= NUM_LVL) |-> sel_flat[s*NUM_LVL +: NUM_LVL] == '0);
  end

endmodule

bind irq_level_router irq_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W), .REG_W(REG_W),
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_irq(src_irq),
  .lvl_irq(lvl_irq), .cfg_flat(cfg_flat), .sel_flat(sel_flat)
);

// File: tb/sim_irq_level_router.sv
`timescale 1ns/1ps
module sim_irq_level_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] src_irq = '0;
  logic [6:0]  lvl_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [3];

  always #4 clk = ~clk;

  irq_level_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_irq(src_irq), .lvl_irq(lvl_irq)
  );

  function automatic logic [6:0] expect_levels(input logic [23:0] s);
    logic [6:0] r = '0;
    for (int i = 0; i < 24; i++) begin
      int unsigned code = model[i / 8][4*(i % 8) +: 4];
      if (code < 7 && s[i]) r[code] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_defaults();
    model[0] = 32'h1000_0000;
    model[1] = 32'h3332_2221;
    model[2] = 32'h6665_5444;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 2'd3) model[a] = d;
  endtask

  task automatic check_words(input string req);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a); #1;
      check(req, $sformatf("word %0d", a), reg_rdata, model[a]);
    end
  endtask

  task automatic check_route(input string req, input logic [23:0] s);
    src_irq = s; #1;
    check(req, $sformatf("route src=%h", s), 32'(lvl_irq), 32'(expect_levels(s)));
  endtask

  // R2 R1 R3: reset words and each source alone on its default level.
  task automatic t_reset_defaults();
    @(negedge clk);
    src_irq = '0; #1;
    check("R4", "idle outputs", 32'(lvl_irq), 32'h0);
    check_words("R2");
    for (int s = 0; s < 24; s++) check_route("R3", 24'(1) << s);
  endtask

  // R4: sharing and spreading patterns.
  task automatic t_sharing();
    @(negedge clk);
    check_route("R4", 24'h00_007F);
    check_route("R4", 24'h00_0041);
    check_route("R4", 24'h80_0000 | 24'h00_0001);
    check_route("R4", 24'hFF_FFFF);
    check_route("R4", 24'h15_A5C3);
  endtask

  // R7 R6: a new code acts exactly one edge after the write.
  task automatic t_remap();
    @(negedge clk);
    src_irq = 24'h00_0008;
    reg_addr = 2'd0; reg_wdata = 32'h1000_5000; reg_we = 1'b1; #1;
    check("R7", "before edge lvl", 32'(lvl_irq), 32'h01);
    check("R7", "before edge rdata", reg_rdata, 32'h1000_0000);
    @(negedge clk);
    reg_we = 1'b0; model[0] = 32'h1000_5000; #1;
    check("R7", "after edge lvl", 32'(lvl_irq), 32'h20);
    check("R6", "after edge rdata", reg_rdata, 32'h1000_5000);
    do_write(2'd2, 32'h6660_5444);
    check_words("R6");
    check_route("R4", 24'h10_0001);
    check_route("R3", 24'h10_0000);
  endtask

  // R5: codes 7 and 15 disconnect.
  task automatic t_disconnect();
    do_write(2'd1, 32'hF332_2227);
    check_route("R5", 24'h00_0100);
    check_route("R5", 24'h00_8000);
    check_route("R5", 24'h00_8100);
    check_route("R4", 24'hFF_FFFF);
  endtask

  // R8: unused address.
  task automatic t_out_of_bank();
    do_write(2'd3, 32'hFFFF_FFFF);
    reg_addr = 2'd3; #1;
    check("R8", "read addr 3", reg_rdata, 32'h0);
    check_words("R8");
    check_route("R8", 24'hFF_FFFF);
  endtask

  // R9: no strobe, no change.
  task automatic t_hold();
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'(a); reg_wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    check_words("R9");
    check_route("R9", 24'hFF_FFFF);
  endtask

  // R2: a second reset restores the default grouping.
  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0; #1;
    load_defaults();
    check_words("R2");
    @(negedge clk);
    rst_n = 1'b1;
    check_route("R2", 24'h00_0008);
  endtask

  initial begin
    load_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_defaults();
    t_sharing();
    t_remap();
    t_disconnect();
    t_out_of_bank();
    t_hold();
    t_rereset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule